// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a free-running input clock into a train of single-cycle enable pulses whose average spacing can be set in fine steps. The spacing is two input cycles plus a programmed value D divided by 2^FRAC_W. With the default widths (32-bit D, 27 fractional bits), the average output rate is the input rate times 2^27 / (2^28 + D). Each period lasts a whole number of cycles. A fractional phase accumulator adds one extra cycle whenever it carries, so across 2^FRAC_W periods the cycle count comes out exact.

Two companion pulse trains come out alongside the main one. One fires on every second main pulse and the other on every fourth. Both line up cycle-for-cycle with the main pulse they sample. Software programs the block through a plain write/read register port. Byte address 0 holds D. Byte address 4 holds a gate bit: the value 1 stops all three outputs and 0 lets them run. Downstream logic uses the pulses as clock enables in the same clock domain.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, the divisor register reads 0, the control register reads 1 (gated), and tick, tick_div2 and tick_div4 stay low.
- R2: A write to byte address 0 stores all DIV_W bits of wr_data as D. A write to byte address 4 stores only wr_data bit 0 as the gate bit, and the upper bits of that register read as 0. Any other address reads 0, and writes to it change neither register.
- R3: While the gate bit is 1, all three outputs are low, from the second clock edge after the gating write onward. After a write of 0 to the gate bit, the first main pulse is high in the cycle that follows the next clock edge.
- R4: Each main pulse is one input cycle wide. Let I = D >> FRAC_W, let F be the low FRAC_W bits of D, and number the periods from k = 1 starting at the first pulse after enabling. The k-th period is then 2 + I + floor(k·F/2^FRAC_W) − floor((k−1)·F/2^FRAC_W) cycles long.
- R5: When F = 0, every period is exactly 2 + I cycles long; D = 0 gives a pulse every second cycle.
- R6: Over any 2^FRAC_W consecutive periods with D held constant, the total number of input cycles equals 2^(FRAC_W+1) + D exactly.
- R7: A new D written in the middle of a period does not change that period. It sets the length of the next period.
- R8: The main pulses are numbered from 0 after enabling. tick_div2 pulses together with every even-numbered main pulse and tick_div4 together with every main pulse whose number is a multiple of 4. Neither pulses without a main pulse.
- R9: Gating clears the phase accumulator, the period counter and the companion counters, so each re-enable repeats the same period sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DIV_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DIV_W | Read data (combinational from rd_addr) |
| tick | output | 1 | Main enable pulse, one per output period |
| tick_div2 | output | 1 | Pulse on every second main pulse |
| tick_div4 | output | 1 | Pulse on every fourth main pulse |

## Verification
The bench compares each period length with the floor-difference formula, over the first periods after enabling and over a full accumulator cycle. A design that drops or doubles a carry would show periods that drift, or a total over 2^FRAC_W periods that misses 2^(FRAC_W+1)+D. It tests D = 0 and the largest D, where a narrow period counter would wrap and give a short period. It writes D in the middle of a period to catch a design that reloads early. It re-enables twice and checks that the sequence repeats, which catches phase state left over from before. The companion pulses are checked against the main pulse index, which exposes off-by-one alignment and pulses that appear while the outputs are gated.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;
  localparam int unsigned OFS_DIVISOR = 0;
  localparam int unsigned OFS_CONTROL = 4;
  localparam int unsigned N_COMPANION = 2;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import frac_clk_div_pkg::*;
#(
  parameter int DIV_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DIV_W-1:0]  rd_data,
  output logic [DIV_W-1:0]  div_val,
  output logic              gate
);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIVISOR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CONTROL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_val <= '0;
      gate    <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == A_DIV)  div_val <= wr_data;
      if (wr_addr == A_CTRL) gate    <= wr_data[0];
    end
  end

  always_comb begin
    if (rd_addr == A_DIV)       rd_data = div_val;
    else if (rd_addr == A_CTRL) rd_data = {{(DIV_W-1){1'b0}}, gate};
    else                        rd_data = '0;
  end
endmodule

// File: rtl/fcd_phase.sv
module fcd_phase #(
  parameter int DIV_W  = 32,
  parameter int FRAC_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             bound,
  output logic             tick
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam int CNT_W = INT_W + 2;

  logic [FRAC_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W:0]   frac_sum;
  logic [CNT_W-1:0]  reload;

  // Fractional part accumulates; its carry stretches the period by one cycle.
  assign frac_sum = {1'b0, acc} + {1'b0, div_val[FRAC_W-1:0]};
  assign reload   = CNT_W'(1) + CNT_W'(div_val[DIV_W-1:FRAC_W]) + CNT_W'(frac_sum[FRAC_W]);
  assign bound    = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      acc  <= '0;
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      tick <= 1'b1;
      cnt  <= reload;
      acc  <= frac_sum[FRAC_W-1:0];
    end else begin
      tick <= 1'b0;
      cnt  <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fcd_companion.sv
module fcd_companion #(
  parameter int N_SUB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bound,
  output logic [N_SUB-1:0] sub_tick
);
  logic [N_SUB-1:0] sub_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  sub_cnt <= '0;
    else if (bound)      sub_cnt <= sub_cnt + N_SUB'(1);
  end

  // Stage i fires when the low i+1 bits of the pulse index are zero (divide by 2^(i+1)).
  for (genvar i = 0; i < N_SUB; i++) begin : g_sub
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n || !run) q <= 1'b0;
      else                q <= bound && ~|sub_cnt[i:0];
    end
    assign sub_tick[i] = q;
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_clk_div_pkg::*;
#(
  parameter int DIV_W  = 32,
  parameter int FRAC_W = 27,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DIV_W-1:0]  rd_data,
  output logic              tick,
  output logic              tick_div2,
  output logic              tick_div4
);
  logic [DIV_W-1:0]       div_val;
  logic                   gate;
  logic                   bound;
  logic [N_COMPANION-1:0] sub_tick;

  fcd_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .div_val(div_val), .gate(gate)
  );

  fcd_phase #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(!gate), .div_val(div_val),
    .bound(bound), .tick(tick)
  );

  fcd_companion #(.N_SUB(N_COMPANION)) u_comp (
    .clk(clk), .rst_n(rst_n), .run(!gate), .bound(bound), .sub_tick(sub_tick)
  );

  assign tick_div2 = sub_tick[0];
  assign tick_div4 = sub_tick[1];
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int DIV_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate,
  input logic              tick,
  input logic              tick_div2,
  input logic              tick_div4,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DIV_W-1:0]  rd_data
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R4
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) gate |=> (!tick && !tick_div2 && !tick_div4)); // R3
  AST_DIV2_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n) tick_div2 |-> tick); // R8
  AST_DIV4_NEEDS_DIV2: assert property (@(posedge clk) disable iff (!rst_n) tick_div4 |-> tick_div2); // R8
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_addr == ADDR_W'(4)) |-> (rd_data[DIV_W-1:1] == '0)); // R2
  AST_DIV2_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tick_div2 |=> !tick_div2); // R8
endmodule

bind frac_clk_div frac_clk_div_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .tick(tick), .tick_div2(tick_div2),
  .tick_div4(tick_div4), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_frac_clk_div.sv
`timescale 1ns/1ps
module sim_frac_clk_div;
  localparam int FW = 8;
  localparam int DW = 12;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          tick, tick_div2, tick_div4;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  frac_clk_div #(.DIV_W(DW), .FRAC_W(FW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .tick_div2(tick_div2),
    .tick_div4(tick_div4)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(negedge clk);
    rd_addr = AW'(a);
    #1 d = int'(rd_data);
  endtask

  // Number of negedges until tick is seen high (200 means it never came).
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 200);
  endtask

  function automatic int exp_len(input int d, input int k);
    int f;
    f = d % (1 << FW);
    return 2 + (d >> FW) + (((k * f) >> FW) - (((k - 1) * f) >> FW));
  endfunction

  task automatic restart(input int d);
    reg_wr(4, 1);
    repeat (3) @(negedge clk);
    reg_wr(0, d);
    reg_wr(4, 0);
  endtask

  task automatic t_reset;
    int v, seen;
    reg_rd(0, v); chk("R1", "divisor after reset", v, 0);
    reg_rd(4, v); chk("R1", "control after reset", v, 1);
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (tick || tick_div2 || tick_div4) seen++;
    end
    chk("R1", "pulses after reset", seen, 0);
  endtask

  task automatic t_regs;
    int v;
    reg_wr(0, 'hABC);
    reg_rd(0, v); chk("R2", "divisor readback", v, 'hABC);
    reg_wr(4, 'hFFF);
    reg_rd(4, v); chk("R2", "control keeps only bit 0", v, 1);
    reg_wr(8, 'h123);
    reg_rd(8, v); chk("R2", "unmapped read", v, 0);
    reg_rd(0, v); chk("R2", "divisor after unmapped write", v, 'hABC);
    reg_rd(4, v); chk("R2", "control after unmapped write", v, 1);
  endtask

  task automatic t_integer(input int d);
    int n, bad;
    restart(d);
    wait_tick(n); chk("R3", "cycles to first pulse", n, 1);
    bad = 0;
    for (int k = 1; k <= 8; k++) begin
      wait_tick(n);
      if (n != 2 + (d >> FW)) bad++;
    end
    chk("R5", "integer periods off", bad, 0);
    wait_tick(n); chk("R5", "integer period length", n, 2 + (d >> FW));
  endtask

  task automatic t_fraction(input int d, input string req);
    int n, bad, total;
    restart(d);
    wait_tick(n); chk("R3", "first pulse after enable", n, 1);
    bad = 0;
    for (int k = 1; k <= 12; k++) begin
      wait_tick(n);
      if (n != exp_len(d, k)) begin
        bad++;
        $display("FAIL %s period %0d: actual %0d expected %0d", req, k, n, exp_len(d, k));
      end
    end
    chk(req, "fractional period mismatches", bad, 0);
    total = 0;
    for (int k = 0; k < (1 << FW); k++) begin
      wait_tick(n);
      total += n;
    end
    chk("R6", "cycles over 2^FW periods", total, (1 << (FW + 1)) + d);
  endtask

  task automatic t_midperiod;
    int n;
    restart(10 << FW);
    wait_tick(n);
    repeat (3) @(negedge clk);
    reg_wr(0, 3 << FW);
    wait_tick(n); chk("R7", "period holding mid-period write", n, 12 - 5);
    wait_tick(n); chk("R7", "period after boundary", n, 5);
  endtask

  task automatic t_companion;
    int n, bad, stray;
    restart(1 << FW);
    bad = 0; stray = 0;
    for (int k = 0; k < 16; k++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (!tick && (tick_div2 || tick_div4)) stray++;
      end while (!tick && n < 200);
      if (int'(tick_div2) != int'(k % 2 == 0)) bad++;
      if (int'(tick_div4) != int'(k % 4 == 0)) bad++;
    end
    chk("R8", "companion alignment errors", bad, 0);
    chk("R8", "companion pulses without main", stray, 0);
  endtask

  task automatic t_gate;
    int seen, v;
    reg_wr(4, 1);
    @(negedge clk);
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (tick || tick_div2 || tick_div4) seen++;
    end
    chk("R3", "pulses while gated", seen, 0);
    reg_rd(4, v); chk("R3", "control reads gated", v, 1);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_integer(3 << FW);
    t_integer(0);
    t_integer(15 << FW);
    t_fraction('h2A5, "R4");
    t_fraction('h2A5, "R9");
    t_fraction('hFFF, "R4");
    t_fraction('h081, "R4");
    t_midperiod();
    t_companion();
    t_gate();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule